// File: doc/BRIEF.md
# MSI Private Cache Coherence Controller

This block keeps one core's private cache coherent with the rest of the system. The cache is a small direct-mapped array of single-word lines. Each line carries a tag, a data word and a coherence state. A line can be Invalid, Shared or Modified, or it can sit in a transient state while a miss for it is in flight. Core loads and stores that hit complete locally. A miss turns into a request to the home directory. The directory's grants, write-back acknowledgements and invalidations come back on a single inbound message channel. Invalidation acknowledgements leave on a dedicated outbound channel.

When a new miss displaces a Modified line, the victim's address and data move into a one-entry buffer next to the array. The dirty write-back is sent at once, and the new miss request follows on the very next cycle, without waiting for the write-back to be acknowledged. The buffer answers invalidations for the victim address until the acknowledgement frees it. The controller also resolves the race in which two caches upgrade the same line at once: if this cache loses and is invalidated while its upgrade is pending, the upgrade becomes a plain exclusive miss and keeps waiting for its grant.

Top module: `msi_cache_ctrl`

## Requirements
- R1: A load whose address matches the tag of a line in Shared or Modified returns that line's word on core_resp_rdata, with core_resp_valid high for one cycle, on the cycle after acceptance. No directory request is sent.
- R2: A load that misses sends a shared request (dreq_type 0) for its address on the cycle after acceptance. A Shared line being displaced is dropped without any message. The line is installed as Shared with dmsg_data when a shared grant (dmsg_type 0) for that address arrives, and that word is returned to the core on the next cycle.
- R3: A store to a line that is not Modified (Invalid, Shared, or a different tag) sends an exclusive request (dreq_type 1). The store completes only on the cycle after an exclusive grant (dmsg_type 1) arrives. The line then becomes Modified and holds the store word, and the grant's data field is ignored.
- R4: A store that hits a Modified line updates the word and responds on the next cycle with the stored word echoed. No directory request is sent.
- R5: An invalidation (dmsg_type 3) produces ack_valid for its address on the next cycle. For a Shared line, ack_dirty is 0 and the line becomes Invalid.
- R6: An invalidation of a Modified line acknowledges with ack_dirty 1 and the line's word on ack_data, and the line becomes Invalid.
- R7: An invalidation that hits a line whose Shared-to-Modified upgrade is pending acknowledges with ack_dirty 0. The store stays outstanding with no core response, and the later exclusive grant completes it with the line Modified.
- R8: A miss that displaces a Modified line moves the victim to the write-back buffer. It sends a write-back request (dreq_type 2) with the victim address and data on the cycle after acceptance, and sends the miss request on the following cycle. A write-back acknowledgement (dmsg_type 2) for the buffered address frees the buffer.
- R9: An invalidation whose address equals the buffered victim's address is acknowledged with ack_dirty 1 and the buffered data.
- R10: Only one miss is outstanding. core_req_ready is low from the acceptance of a miss until the cycle after its grant. It is also low while a directory message is being presented, and for a request to the buffered address or one that would need a second buffered victim.
- R11: A grant that does not match the pending miss's address and transient state, or a write-back acknowledgement that does not match the buffer, raises proto_err for exactly one cycle and changes no line. proto_err never rises without such a message.
- R12: After reset every line is Invalid, the buffer is empty, core_req_ready is high and every valid output and proto_err are low.
- R13: The line index is the low log2(SETS) address bits and the tag is the remaining upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req_valid | input | 1 | Core request present |
| core_req_ready | output | 1 | Request accepted on this edge when high |
| core_req_write | input | 1 | 1 = store, 0 = load |
| core_req_addr | input | AW | Word address |
| core_req_wdata | input | DW | Store data |
| core_resp_valid | output | 1 | One-cycle completion pulse |
| core_resp_rdata | output | DW | Load data or echoed store data |
| dreq_valid | output | 1 | Request to directory |
| dreq_type | output | 2 | 0 shared, 1 exclusive, 2 write-back |
| dreq_addr | output | AW | Request address |
| dreq_data | output | DW | Write-back data |
| dmsg_valid | input | 1 | Directory message present |
| dmsg_type | input | 2 | 0 shared grant, 1 exclusive grant, 2 write-back ack, 3 invalidate |
| dmsg_addr | input | AW | Message address |
| dmsg_data | input | DW | Grant data |
| ack_valid | output | 1 | Invalidation acknowledgement |
| ack_addr | output | AW | Acknowledged address |
| ack_dirty | output | 1 | ack_data carries modified data |
| ack_data | output | DW | Dirty data |
| proto_err | output | 1 | Unexpected-message pulse |

## Verification
The assertions watch, on every cycle, the handshake shape of the controller. An accepted miss always stalls the core, and a directory request never appears while the core could be accepted. Every invalidation is acknowledged one cycle later for the same address, and a write-back request is always followed at once by a miss request. A stray write-back acknowledgement always raises the error pulse, and that pulse never rises without a message. What ends up in the array can only be shown by the bench's scenarios. These cover installed data and states, the silent drop of Shared victims, dirty data in acknowledgements, resolution of the upgrade race, service of the victim from the buffer, and the fact that a rejected grant leaves the line untouched.

// File: rtl/msi_cc_pkg.sv
package msi_cc_pkg;
    typedef enum logic [2:0] {
        LS_I  = 3'd0,
        LS_S  = 3'd1,
        LS_M  = 3'd2,
        LS_IS = 3'd4,
        LS_IM = 3'd5,
        LS_SM = 3'd6
    } line_st_e;

    typedef enum logic [1:0] {
        OUT_GETS = 2'd0,
        OUT_GETX = 2'd1,
        OUT_PUTM = 2'd2
    } out_req_e;

    typedef enum logic [1:0] {
        IN_GRANT_S = 2'd0,
        IN_GRANT_X = 2'd1,
        IN_PUT_ACK = 2'd2,
        IN_INV     = 2'd3
    } in_msg_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WB   = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_cc_pkg::*;
#(
    parameter int SETS = 4,
    parameter int TW   = 6,
    parameter int DW   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] a_idx,
    output line_st_e                a_st,
    output logic [TW-1:0]           a_tag,
    output logic [DW-1:0]           a_data,
    input  logic [$clog2(SETS)-1:0] b_idx,
    output line_st_e                b_st,
    output logic [TW-1:0]           b_tag,
    output logic [DW-1:0]           b_data,
    input  logic                    we,
    input  logic [$clog2(SETS)-1:0] w_idx,
    input  line_st_e                w_st,
    input  logic [TW-1:0]           w_tag,
    input  logic [DW-1:0]           w_data
);
    localparam int IW = $clog2(SETS);

    line_st_e      st_all   [SETS];
    logic [TW-1:0] tag_all  [SETS];
    logic [DW-1:0] data_all [SETS];

    for (genvar g = 0; g < SETS; g++) begin : g_line
        line_st_e      st_d, st_q;
        logic [TW-1:0] tag_d, tag_q;
        logic [DW-1:0] data_d, data_q;

        always_comb begin
            st_d   = st_q;
            tag_d  = tag_q;
            data_d = data_q;
            if (we && w_idx == IW'(g)) begin
                st_d   = w_st;
                tag_d  = w_tag;
                data_d = w_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q   <= LS_I;
                tag_q  <= '0;
                data_q <= '0;
            end else begin
                st_q   <= st_d;
                tag_q  <= tag_d;
                data_q <= data_d;
            end
        end

        assign st_all[g]   = st_q;
        assign tag_all[g]  = tag_q;
        assign data_all[g] = data_q;
    end

    assign a_st   = st_all[a_idx];
    assign a_tag  = tag_all[a_idx];
    assign a_data = data_all[a_idx];
    assign b_st   = st_all[b_idx];
    assign b_tag  = tag_all[b_idx];
    assign b_data = data_all[b_idx];
endmodule

// File: rtl/msi_victim_buf.sv
module msi_victim_buf #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic          clear,
    output logic          valid,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    typedef struct packed {
        logic          v;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } vb_t;

    vb_t vb_d, vb_q;

    always_comb begin
        vb_d = vb_q;
        if (clear) begin
            vb_d.v = 1'b0;
        end
        if (load) begin
            vb_d.v = 1'b1;
            vb_d.a = load_addr;
            vb_d.d = load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vb_q <= '0;
        end else begin
            vb_q <= vb_d;
        end
    end

    assign valid = vb_q.v;
    assign addr  = vb_q.a;
    assign data  = vb_q.d;
endmodule

// File: rtl/msi_cache_ctrl.sv
module msi_cache_ctrl
    import msi_cc_pkg::*;
#(
    parameter int AW   = 8,
    parameter int DW   = 16,
    parameter int SETS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_req_valid,
    output logic          core_req_ready,
    input  logic          core_req_write,
    input  logic [AW-1:0] core_req_addr,
    input  logic [DW-1:0] core_req_wdata,
    output logic          core_resp_valid,
    output logic [DW-1:0] core_resp_rdata,
    output logic          dreq_valid,
    output logic [1:0]    dreq_type,
    output logic [AW-1:0] dreq_addr,
    output logic [DW-1:0] dreq_data,
    input  logic          dmsg_valid,
    input  logic [1:0]    dmsg_type,
    input  logic [AW-1:0] dmsg_addr,
    input  logic [DW-1:0] dmsg_data,
    output logic          ack_valid,
    output logic [AW-1:0] ack_addr,
    output logic          ack_dirty,
    output logic [DW-1:0] ack_data,
    output logic          proto_err
);
    localparam int IW = $clog2(SETS);
    localparam int TW = AW - IW;

    typedef struct packed {
        phase_e        ph;
        logic [AW-1:0] paddr;
        logic          pwrite;
        logic [DW-1:0] pwdata;
        logic          dq_v;
        out_req_e      dq_t;
        logic [AW-1:0] dq_a;
        logic [DW-1:0] dq_d;
        logic          ak_v;
        logic [AW-1:0] ak_a;
        logic          ak_dirty;
        logic [DW-1:0] ak_d;
        logic          rs_v;
        logic [DW-1:0] rs_d;
        logic          err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // array ports
    line_st_e      a_st, b_st, w_st;
    logic [TW-1:0] a_tag, b_tag, w_tag;
    logic [DW-1:0] a_data, b_data, w_data;
    logic [IW-1:0] w_idx;
    logic          we;

    // victim buffer ports
    logic          wbb_load, wbb_clear, wbb_valid;
    logic [AW-1:0] wbb_load_addr, wbb_addr;
    logic [DW-1:0] wbb_load_data, wbb_data;

    logic [IW-1:0] c_idx, m_idx;
    logic [TW-1:0] c_tag, m_tag;
    logic          tag_hit, need_miss, victim_dirty, ready;
    in_msg_e       mtype;

    assign c_idx = core_req_addr[IW-1:0];
    assign c_tag = core_req_addr[AW-1:IW];
    assign m_idx = dmsg_addr[IW-1:0];
    assign m_tag = dmsg_addr[AW-1:IW];
    assign mtype = in_msg_e'(dmsg_type);

    msi_line_store #(.SETS(SETS), .TW(TW), .DW(DW)) i_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_idx  (c_idx),
        .a_st   (a_st),
        .a_tag  (a_tag),
        .a_data (a_data),
        .b_idx  (m_idx),
        .b_st   (b_st),
        .b_tag  (b_tag),
        .b_data (b_data),
        .we     (we),
        .w_idx  (w_idx),
        .w_st   (w_st),
        .w_tag  (w_tag),
        .w_data (w_data)
    );

    msi_victim_buf #(.AW(AW), .DW(DW)) i_vbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wbb_load),
        .load_addr (wbb_load_addr),
        .load_data (wbb_load_data),
        .clear     (wbb_clear),
        .valid     (wbb_valid),
        .addr      (wbb_addr),
        .data      (wbb_data)
    );

    always_comb begin
        tag_hit      = (a_tag == c_tag);
        victim_dirty = (a_st == LS_M) && !tag_hit;
        if (core_req_write) begin
            need_miss = !(tag_hit && a_st == LS_M);
        end else begin
            need_miss = !(tag_hit && (a_st == LS_S || a_st == LS_M));
        end
        ready = (ctl_q.ph == PH_IDLE) && !dmsg_valid
             && !(wbb_valid && wbb_addr == core_req_addr)
             && !(need_miss && victim_dirty && wbb_valid);
    end

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.dq_v    = 1'b0;
        ctl_d.ak_v    = 1'b0;
        ctl_d.rs_v    = 1'b0;
        ctl_d.err     = 1'b0;
        we            = 1'b0;
        w_idx         = c_idx;
        w_st          = a_st;
        w_tag         = a_tag;
        w_data        = a_data;
        wbb_load      = 1'b0;
        wbb_load_addr = {a_tag, c_idx};
        wbb_load_data = a_data;
        wbb_clear     = 1'b0;

        // miss request follows a write-back issued last cycle
        if (ctl_q.ph == PH_WB) begin
            ctl_d.dq_v = 1'b1;
            ctl_d.dq_t = ctl_q.pwrite ? OUT_GETX : OUT_GETS;
            ctl_d.dq_a = ctl_q.paddr;
            ctl_d.dq_d = '0;
            ctl_d.ph   = PH_WAIT;
        end

        if (core_req_valid && ready) begin
            if (!need_miss) begin
                ctl_d.rs_v = 1'b1;
                if (core_req_write) begin
                    we         = 1'b1;
                    w_data     = core_req_wdata;
                    ctl_d.rs_d = core_req_wdata;
                end else begin
                    ctl_d.rs_d = a_data;
                end
            end else begin
                we    = 1'b1;
                w_tag = c_tag;
                if (!core_req_write) begin
                    w_st = LS_IS;
                end else if (tag_hit && a_st == LS_S) begin
                    w_st = LS_SM;
                end else begin
                    w_st = LS_IM;
                end
                ctl_d.paddr  = core_req_addr;
                ctl_d.pwrite = core_req_write;
                ctl_d.pwdata = core_req_wdata;
                ctl_d.dq_v   = 1'b1;
                if (victim_dirty) begin
                    wbb_load   = 1'b1;
                    ctl_d.dq_t = OUT_PUTM;
                    ctl_d.dq_a = {a_tag, c_idx};
                    ctl_d.dq_d = a_data;
                    ctl_d.ph   = PH_WB;
                end else begin
                    ctl_d.dq_t = core_req_write ? OUT_GETX : OUT_GETS;
                    ctl_d.dq_a = core_req_addr;
                    ctl_d.dq_d = '0;
                    ctl_d.ph   = PH_WAIT;
                end
            end
        end

        if (dmsg_valid) begin
            w_idx  = m_idx;
            w_tag  = b_tag;
            w_data = b_data;
            w_st   = b_st;
            unique case (mtype)
                IN_INV: begin
                    ctl_d.ak_v     = 1'b1;
                    ctl_d.ak_a     = dmsg_addr;
                    ctl_d.ak_dirty = 1'b0;
                    ctl_d.ak_d     = '0;
                    if (wbb_valid && wbb_addr == dmsg_addr) begin
                        ctl_d.ak_dirty = 1'b1;
                        ctl_d.ak_d     = wbb_data;
                    end else if (b_tag == m_tag) begin
                        if (b_st == LS_M) begin
                            we             = 1'b1;
                            w_st           = LS_I;
                            ctl_d.ak_dirty = 1'b1;
                            ctl_d.ak_d     = b_data;
                        end else if (b_st == LS_S) begin
                            we   = 1'b1;
                            w_st = LS_I;
                        end else if (b_st == LS_SM) begin
                            we   = 1'b1;
                            w_st = LS_IM;
                        end
                    end
                end
                IN_GRANT_S: begin
                    if (ctl_q.ph == PH_WAIT && ctl_q.paddr == dmsg_addr
                        && b_tag == m_tag && b_st == LS_IS) begin
                        we         = 1'b1;
                        w_st       = LS_S;
                        w_data     = dmsg_data;
                        ctl_d.rs_v = 1'b1;
                        ctl_d.rs_d = dmsg_data;
                        ctl_d.ph   = PH_IDLE;
                    end else begin
                        ctl_d.err = 1'b1;
                    end
                end
                IN_GRANT_X: begin
                    if (ctl_q.ph == PH_WAIT && ctl_q.paddr == dmsg_addr
                        && b_tag == m_tag && (b_st == LS_IM || b_st == LS_SM)) begin
                        we         = 1'b1;
                        w_st       = LS_M;
                        w_data     = ctl_q.pwdata;
                        ctl_d.rs_v = 1'b1;
                        ctl_d.rs_d = ctl_q.pwdata;
                        ctl_d.ph   = PH_IDLE;
                    end else begin
                        ctl_d.err = 1'b1;
                    end
                end
                IN_PUT_ACK: begin
                    if (wbb_valid && wbb_addr == dmsg_addr) begin
                        wbb_clear = 1'b1;
                    end else begin
                        ctl_d.err = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.ph <= PH_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign core_req_ready  = ready;
    assign core_resp_valid = ctl_q.rs_v;
    assign core_resp_rdata = ctl_q.rs_d;
    assign dreq_valid      = ctl_q.dq_v;
    assign dreq_type       = ctl_q.dq_t;
    assign dreq_addr       = ctl_q.dq_a;
    assign dreq_data       = ctl_q.dq_d;
    assign ack_valid       = ctl_q.ak_v;
    assign ack_addr        = ctl_q.ak_a;
    assign ack_dirty       = ctl_q.ak_dirty;
    assign ack_data        = ctl_q.ak_d;
    assign proto_err       = ctl_q.err;
endmodule

module msi_cc_checker #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          core_req_valid,
    input logic          core_req_ready,
    input logic          core_resp_valid,
    input logic          dreq_valid,
    input logic [1:0]    dreq_type,
    input logic          dmsg_valid,
    input logic [1:0]    dmsg_type,
    input logic [AW-1:0] dmsg_addr,
    input logic          ack_valid,
    input logic [AW-1:0] ack_addr,
    input logic          proto_err,
    input logic          wbb_valid
);
    assert_accept_then_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req_valid && core_req_ready) |=> (!core_req_ready || core_resp_valid));

    assert_req_blocks_core_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dreq_valid |-> !core_req_ready);

    assert_wb_then_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq_valid && dreq_type == 2'd2) |=> (dreq_valid && dreq_type != 2'd2));

    assert_dreq_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dreq_valid |-> dreq_type != 2'd3);

    assert_inv_acked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dmsg_valid && dmsg_type == 2'd3) |=> (ack_valid && ack_addr == $past(dmsg_addr)));

    assert_stray_wback_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dmsg_valid && dmsg_type == 2'd2 && !wbb_valid) |=> proto_err);

    assert_no_spurious_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !dmsg_valid |=> !proto_err);
endmodule

bind msi_cache_ctrl msi_cc_checker #(.AW(AW), .DW(DW)) i_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .core_req_valid  (core_req_valid),
    .core_req_ready  (core_req_ready),
    .core_resp_valid (core_resp_valid),
    .dreq_valid      (dreq_valid),
    .dreq_type       (dreq_type),
    .dmsg_valid      (dmsg_valid),
    .dmsg_type       (dmsg_type),
    .dmsg_addr       (dmsg_addr),
    .ack_valid       (ack_valid),
    .ack_addr        (ack_addr),
    .proto_err       (proto_err),
    .wbb_valid       (wbb_valid)
);

// File: tb/test_msi_cache_ctrl.sv
module test_msi_cache_ctrl;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          core_req_valid, core_req_ready, core_req_write;
    logic [AW-1:0] core_req_addr;
    logic [DW-1:0] core_req_wdata;
    logic          core_resp_valid;
    logic [DW-1:0] core_resp_rdata;
    logic          dreq_valid;
    logic [1:0]    dreq_type;
    logic [AW-1:0] dreq_addr;
    logic [DW-1:0] dreq_data;
    logic          dmsg_valid;
    logic [1:0]    dmsg_type;
    logic [AW-1:0] dmsg_addr;
    logic [DW-1:0] dmsg_data;
    logic          ack_valid;
    logic [AW-1:0] ack_addr;
    logic          ack_dirty;
    logic [DW-1:0] ack_data;
    logic          proto_err;

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 0;

    always #5 clk = ~clk;

    msi_cache_ctrl #(.AW(AW), .DW(DW), .SETS(4)) i_msi_cache_ctrl (.*);

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [15:0] wdata;
        logic [1:0]  msg;   // 0 shared req, 1 exclusive req, 3 none (hit)
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h10, 16'h0000, 2'd0, 16'h104A},
        '{1'b0, 8'h10, 16'h0000, 2'd3, 16'h104A},
        '{1'b1, 8'h10, 16'h1111, 2'd1, 16'h1111},
        '{1'b0, 8'h10, 16'h0000, 2'd3, 16'h1111},
        '{1'b1, 8'h10, 16'h2222, 2'd3, 16'h2222},
        '{1'b0, 8'h10, 16'h0000, 2'd3, 16'h2222},
        '{1'b1, 8'h21, 16'h3333, 2'd1, 16'h3333},
        '{1'b0, 8'h21, 16'h0000, 2'd3, 16'h3333},
        '{1'b0, 8'h32, 16'h0000, 2'd0, 16'h3268},
        '{1'b0, 8'h36, 16'h0000, 2'd0, 16'h366C},
        '{1'b0, 8'h32, 16'h0000, 2'd0, 16'h3268}
    };

    function automatic logic [15:0] mem_val(input logic [7:0] a);
        return {a, a ^ 8'h5A};
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic core_op(input logic wr, input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        core_req_valid = 1'b1;
        core_req_write = wr;
        core_req_addr  = a;
        core_req_wdata = d;
        #1;
        while (!core_req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        core_req_valid = 1'b0;
    endtask

    task automatic dir_msg(input logic [1:0] t, input logic [7:0] a, input logic [15:0] d);
        dmsg_valid = 1'b1;
        dmsg_type  = t;
        dmsg_addr  = a;
        dmsg_data  = d;
        @(negedge clk);
        dmsg_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        core_req_valid = 1'b0; core_req_write = 1'b0; core_req_addr = '0; core_req_wdata = '0;
        dmsg_valid = 1'b0; dmsg_type = '0; dmsg_addr = '0; dmsg_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk(core_req_ready == 1'b1, "R12 ready", 32'(core_req_ready), 1);
        chk(!core_resp_valid && !dreq_valid && !ack_valid && !proto_err, "R12 outputs idle",
            {core_resp_valid, dreq_valid, ack_valid, proto_err}, 0);

        // R1-R4, R13: vector walk with the bench acting as directory
        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = VECS[i].wr ? ((VECS[i].msg == 2'd3) ? "R4" : "R3")
                            : ((VECS[i].msg == 2'd3) ? "R1" : "R2");
            core_op(VECS[i].wr, VECS[i].addr, VECS[i].wdata);
            if (VECS[i].msg == 2'd3) begin
                chk(core_resp_valid && core_resp_rdata == VECS[i].exp, rq, core_resp_rdata, VECS[i].exp);
                chk(!dreq_valid, rq, 32'(dreq_valid), 0);
            end else begin
                chk(dreq_valid && dreq_type == VECS[i].msg && dreq_addr == VECS[i].addr, rq,
                    {dreq_valid, dreq_type, dreq_addr}, {1'b1, VECS[i].msg, VECS[i].addr});
                chk(!core_resp_valid, rq, 32'(core_resp_valid), 0);
                dir_msg(VECS[i].msg, VECS[i].addr, mem_val(VECS[i].addr));
                chk(core_resp_valid && core_resp_rdata == VECS[i].exp, rq, core_resp_rdata, VECS[i].exp);
            end
        end

        // R5: invalidate a Shared line
        dir_msg(2'd3, 8'h32, 16'h0);
        chk(ack_valid && ack_addr == 8'h32 && !ack_dirty, "R5 ack", {ack_valid, ack_addr, ack_dirty}, {1'b1, 8'h32, 1'b0});
        core_op(1'b0, 8'h32, 16'h0);
        chk(dreq_valid && dreq_type == 2'd0, "R5 line now invalid", dreq_type, 0);
        dir_msg(2'd0, 8'h32, mem_val(8'h32));
        chk(core_resp_valid && core_resp_rdata == 16'h3268, "R2 refill", core_resp_rdata, 16'h3268);

        // R6: invalidate a Modified line
        dir_msg(2'd3, 8'h21, 16'h0);
        chk(ack_valid && ack_dirty && ack_data == 16'h3333, "R6 dirty ack", ack_data, 16'h3333);
        core_op(1'b0, 8'h21, 16'h0);
        chk(dreq_valid && dreq_type == 2'd0 && dreq_addr == 8'h21, "R6 line now invalid", dreq_type, 0);
        dir_msg(2'd0, 8'h21, mem_val(8'h21));
        chk(core_resp_valid && core_resp_rdata == 16'h217B, "R2 refill", core_resp_rdata, 16'h217B);

        // R8: dirty victim 0x10 displaced by store to 0x14
        core_op(1'b1, 8'h14, 16'h4444);
        chk(dreq_valid && dreq_type == 2'd2 && dreq_addr == 8'h10 && dreq_data == 16'h2222, "R8 write-back",
            {dreq_type, dreq_addr, dreq_data}, {2'd2, 8'h10, 16'h2222});
        @(negedge clk);
        chk(dreq_valid && dreq_type == 2'd1 && dreq_addr == 8'h14, "R8 miss follows", {dreq_type, dreq_addr}, {2'd1, 8'h14});
        chk(!core_req_ready, "R10 stalled while pending", 32'(core_req_ready), 0);
        // R9: invalidation served from the buffer
        dir_msg(2'd3, 8'h10, 16'h0);
        chk(ack_valid && ack_dirty && ack_data == 16'h2222, "R9 buffer ack", ack_data, 16'h2222);
        dir_msg(2'd1, 8'h14, 16'hDEAD);
        chk(core_resp_valid && core_resp_rdata == 16'h4444, "R3 store completes", core_resp_rdata, 16'h4444);

        // R10: request to the buffered address waits for the write-back ack
        core_req_valid = 1'b1; core_req_write = 1'b0; core_req_addr = 8'h10; core_req_wdata = '0;
        #1;
        chk(!core_req_ready, "R10 buffered address blocked", 32'(core_req_ready), 0);
        dir_msg(2'd2, 8'h10, 16'h0);
        #1;
        chk(core_req_ready, "R10 released by ack", 32'(core_req_ready), 1);
        chk(!proto_err, "R8 ack accepted", 32'(proto_err), 0);
        @(negedge clk);
        core_req_valid = 1'b0;
        chk(dreq_valid && dreq_type == 2'd2 && dreq_addr == 8'h14 && dreq_data == 16'h4444, "R8 second victim",
            {dreq_type, dreq_addr, dreq_data}, {2'd2, 8'h14, 16'h4444});
        @(negedge clk);
        chk(dreq_valid && dreq_type == 2'd0 && dreq_addr == 8'h10, "R8 load miss follows", {dreq_type, dreq_addr}, {2'd0, 8'h10});
        dir_msg(2'd0, 8'h10, mem_val(8'h10));
        chk(core_resp_valid && core_resp_rdata == 16'h104A, "R2 refill", core_resp_rdata, 16'h104A);
        dir_msg(2'd2, 8'h14, 16'h0);
        chk(!proto_err, "R8 ack accepted", 32'(proto_err), 0);

        // R7: upgrade race
        core_op(1'b0, 8'h27, 16'h0);
        dir_msg(2'd0, 8'h27, mem_val(8'h27));
        chk(core_resp_valid && core_resp_rdata == 16'h277D, "R2 load miss", core_resp_rdata, 16'h277D);
        core_op(1'b1, 8'h27, 16'h5555);
        chk(dreq_valid && dreq_type == 2'd1 && dreq_addr == 8'h27, "R7 upgrade request", dreq_type, 1);
        dir_msg(2'd3, 8'h27, 16'h0);
        chk(ack_valid && !ack_dirty && ack_addr == 8'h27, "R7 clean ack", {ack_valid, ack_dirty}, 2'b10);
        chk(!core_resp_valid && !core_req_ready, "R7 still pending", {core_resp_valid, core_req_ready}, 0);
        dir_msg(2'd1, 8'h27, 16'hBEEF);
        chk(core_resp_valid && core_resp_rdata == 16'h5555 && !proto_err, "R7 grant completes", core_resp_rdata, 16'h5555);
        core_op(1'b0, 8'h27, 16'h0);
        chk(core_resp_valid && core_resp_rdata == 16'h5555 && !dreq_valid, "R7 line modified hit", core_resp_rdata, 16'h5555);
        dir_msg(2'd3, 8'h27, 16'h0);
        chk(ack_valid && ack_dirty && ack_data == 16'h5555, "R6 dirty ack", ack_data, 16'h5555);

        // R11: unexpected grant leaves line untouched
        dir_msg(2'd0, 8'h27, 16'h9999);
        chk(proto_err, "R11 stray grant", 32'(proto_err), 1);
        @(negedge clk);
        chk(!proto_err, "R11 single-cycle pulse", 32'(proto_err), 0);
        core_op(1'b0, 8'h27, 16'h0);
        chk(dreq_valid && dreq_type == 2'd0 && !core_resp_valid, "R11 line unchanged", {dreq_valid, dreq_type}, {1'b1, 2'd0});
        dir_msg(2'd0, 8'h27, mem_val(8'h27));
        chk(core_resp_valid && core_resp_rdata == 16'h277D, "R2 refill", core_resp_rdata, 16'h277D);
        dir_msg(2'd2, 8'h40, 16'h0);
        chk(proto_err, "R11 stray write-back ack", 32'(proto_err), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule